// File: doc/BRIEF.md
# UART Receive Idle-Timeout Detector

This block sits beside the receive FIFO of a UART and detects received data that is waiting and not being collected. It counts baud-rate bit ticks while the FIFO holds data but no new character arrives. When the idle time reaches eight character lengths, it sets a sticky status flag. A character length is seven or eight bit times, chosen by a word-size input. The timeout can only occur while the FIFO fill level is above zero and below the programmed receive threshold, because at or above the threshold the normal threshold request already serves the data.

The flag drives an interrupt output and a DMA request output, each gated by its own enable. A driver can therefore drain a partly filled FIFO by interrupt, by DMA, or by both. Software clears the flag by writing 1 to the status bit. The deserializer, the baud generator and the FIFO storage are outside the block. It only observes the FIFO level, the character-written strobe and the bit tick.

Top module: `rx_age_timer`

## Requirements
- R1: After reset the flag, the interrupt and the DMA request are all low.
- R2: With `word_long`=1, the flag is high in the cycle after the 64th bit tick counted since the last character push, provided 0 < `fill_level` < `rx_thresh` throughout. After 63 ticks it is still low.
- R3: With `word_long`=0, the timeout is 56 bit ticks: the flag is low after 55 ticks and high in the cycle after the 56th.
- R4: A `char_push` pulse restarts the idle count from zero, so a full timeout is again required after it.
- R5: While `fill_level` >= `rx_thresh`, the idle count is held at zero and no timeout fires. Counting resumes from zero once the level drops below the threshold.
- R6: While `fill_level` is 0, the count is cleared and the detector disarms. Ticks that arrive after the FIFO has emptied produce no timeout until the next `char_push`.
- R7: After a timeout fires, further ticks produce no second timeout until a new `char_push` arrives.
- R8: The flag is sticky. A cycle with `stat_wr`=1 and `stat_wdata`=1 clears it for the next cycle. A write with `stat_wdata`=0 leaves it unchanged.
- R9: `age_irq` is high exactly when the flag and `irq_en` are both high. `age_dma_req` is high exactly when the flag and `dma_en` are both high. Both fall in the cycle after a clearing write.
- R10: If a timeout fires in the same cycle as a clearing write, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit time |
| char_push | input | 1 | Pulse when a character is written into the FIFO |
| fill_level | input | LVL_W (6) | Current FIFO occupancy, 0..32 |
| rx_thresh | input | LVL_W (6) | Programmed receive threshold |
| word_long | input | 1 | 1: eight-bit characters, 0: seven-bit characters |
| irq_en | input | 1 | Routes the flag to the interrupt output |
| dma_en | input | 1 | Routes the flag to the DMA request output |
| stat_wr | input | 1 | Write strobe for the status bit |
| stat_wdata | input | 1 | Status write data; 1 clears the flag |
| age_flag | output | 1 | Sticky timeout flag |
| age_irq | output | 1 | Timeout interrupt |
| age_dma_req | output | 1 | Timeout DMA request |

## Verification
Two events can fall in the same cycle: a timeout firing on the final bit tick, and a write-1 clear of the flag. The bench first leaves the flag set by an earlier timeout. It then re-arms with a push, runs the count to one tick short of the limit, and drives the last tick together with the clearing write. The flag must read high afterwards, as R10 requires, and a clearing write issued on its own afterwards must drop it. A behavioural reference model tracks the idle count in integers and compares all three outputs on every clock, so the race is also judged cycle by cycle.

// File: rtl/rx_age_pkg.sv
package rx_age_pkg;

  // Timeout length in bit ticks for the selected word size
  function automatic int unsigned char_limit(input int unsigned chars,
                                             input int unsigned bits_short,
                                             input int unsigned bits_long,
                                             input logic        long_sel);
    int unsigned bits;
    bits = long_sel ? bits_long : bits_short;
    return chars * bits;
  endfunction

  // Data is waiting below the threshold: nonempty and under the level
  function automatic logic level_below(input int unsigned fill,
                                       input int unsigned thresh);
    return (fill != 0) && (fill < thresh);
  endfunction

endpackage

// File: rtl/rx_age_qual.sv
module rx_age_qual #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] rx_thresh,
  output logic             fifo_empty,
  output logic             lvl_ok
);
  import rx_age_pkg::*;

  assign fifo_empty = (fill_level == '0);
  assign lvl_ok     = level_below(int'(fill_level), int'(rx_thresh));

  // a qualifying level is never an empty FIFO (R6)
  p_ok_not_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_ok |-> !fifo_empty);
endmodule

// File: rtl/rx_age_counter.sv
module rx_age_counter #(
  parameter int CHARS      = 8,
  parameter int BITS_SHORT = 7,
  parameter int BITS_LONG  = 8,
  localparam int MAX_TICKS = CHARS * BITS_LONG,
  localparam int CNT_W     = $clog2(MAX_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic char_push,
  input  logic fifo_empty,
  input  logic lvl_ok,
  input  logic word_long,
  output logic fire,
  output logic armed
);
  import rx_age_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             counting;

  assign last_cnt = CNT_W'(char_limit(CHARS, BITS_SHORT, BITS_LONG, word_long) - 1);
  assign counting = armed && lvl_ok && !char_push && bit_tick;
  assign fire     = counting && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      armed <= 1'b0;
    end else if (char_push) begin
      cnt_q <= '0;
      armed <= 1'b1;
    end else if (fifo_empty) begin
      cnt_q <= '0;
      armed <= 1'b0;
    end else if (!lvl_ok) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= '0;
      armed <= 1'b0;
    end else if (counting) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt || !armed || !lvl_ok);
  p_push_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    char_push |=> (cnt_q == '0) && armed);
  p_hold_at_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_ok && !char_push) |=> cnt_q == '0);
  p_fire_needs_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> lvl_ok);
  p_empty_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !char_push) |=> !armed);
  p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);
endmodule

// File: rtl/rx_age_status.sv
module rx_age_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic stat_wr,
  input  logic stat_wdata,
  output logic flag
);
  logic clr;
  assign clr = stat_wr && stat_wdata;

  // a timeout in the clearing cycle wins (R10)
  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (fire)  flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end

  p_set_on_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> flag);
  p_clear_w1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !flag);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !fire) |=> !flag);
endmodule

// File: rtl/rx_age_timer.sv
module rx_age_timer #(
  parameter int FIFO_DEPTH = 32,
  parameter int CHARS      = 8,
  parameter int BITS_SHORT = 7,
  parameter int BITS_LONG  = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             char_push,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic             word_long,
  input  logic             irq_en,
  input  logic             dma_en,
  input  logic             stat_wr,
  input  logic             stat_wdata,
  output logic             age_flag,
  output logic             age_irq,
  output logic             age_dma_req
);
  logic fifo_empty;
  logic lvl_ok;
  logic fire;
  logic armed;

  rx_age_qual #(.LVL_W(LVL_W)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_level (fill_level),
    .rx_thresh  (rx_thresh),
    .fifo_empty (fifo_empty),
    .lvl_ok     (lvl_ok)
  );

  rx_age_counter #(
    .CHARS(CHARS), .BITS_SHORT(BITS_SHORT), .BITS_LONG(BITS_LONG)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .char_push  (char_push),
    .fifo_empty (fifo_empty),
    .lvl_ok     (lvl_ok),
    .word_long  (word_long),
    .fire       (fire),
    .armed      (armed)
  );

  rx_age_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .flag       (age_flag)
  );

  assign age_irq     = age_flag && irq_en;
  assign age_dma_req = age_flag && dma_en;

  p_outputs_need_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !age_flag |-> (!age_irq && !age_dma_req));
  p_clear_drops_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata && !fire) |=> (!age_irq && !age_dma_req));
  p_fire_while_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> armed);
endmodule

// File: tb/rx_age_timer_tb.sv
module rx_age_timer_tb;
  localparam int LVL_W = 6;
  localparam time HALF = 2ns;

  logic clk = 0, rst_n = 0;
  logic bit_tick = 0, char_push = 0, word_long = 1;
  logic irq_en = 0, dma_en = 0, stat_wr = 0, stat_wdata = 0;
  logic [LVL_W-1:0] fill_level = 0, rx_thresh = 8;
  logic age_flag, age_irq, age_dma_req;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #HALF clk = ~clk;

  rx_age_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_push(char_push),
    .fill_level(fill_level), .rx_thresh(rx_thresh), .word_long(word_long),
    .irq_en(irq_en), .dma_en(dma_en), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .age_flag(age_flag), .age_irq(age_irq),
    .age_dma_req(age_dma_req)
  );

  // behavioural reference: idle ticks since last push
  int  m_idle;
  bit  m_live;
  bit  m_flag;
  always @(posedge clk) begin
    int  lim;
    bit  hit;
    lim = word_long ? 64 : 56;
    hit = 0;
    if (!rst_n) begin
      m_idle = 0; m_live = 0; m_flag = 0;
    end else begin
      if (char_push) begin
        m_idle = 0; m_live = 1;
      end else if (fill_level == 0) begin
        m_idle = 0; m_live = 0;
      end else if (fill_level >= rx_thresh) begin
        m_idle = 0;
      end else if (bit_tick && m_live) begin
        m_idle++;
        if (m_idle >= lim) begin
          hit = 1; m_live = 0; m_idle = 0;
        end
      end
      if (hit) m_flag = 1;
      else if (stat_wr && stat_wdata) m_flag = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // compare every clock, 1ns after the edge, inputs stable
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !finished) begin
      check("R9 model flag", age_flag, m_flag);
      check("R9 model irq", age_irq, m_flag && irq_en);
      check("R9 model dma", age_dma_req, m_flag && dma_en);
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1;
      @(negedge clk) bit_tick = 0;
    end
  endtask

  task automatic push();
    @(negedge clk) char_push = 1;
    @(negedge clk) char_push = 0;
  endtask

  task automatic wr_stat(input logic d);
    @(negedge clk) begin stat_wr = 1; stat_wdata = d; end
    @(negedge clk) begin stat_wr = 0; stat_wdata = 0; end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag", age_flag, 0);
    check("R1 irq", age_irq, 0);
    check("R1 dma", age_dma_req, 0);
    rst_n = 1;
    fill_level = 3; rx_thresh = 8; irq_en = 1; word_long = 1;

    // R2: 64 ticks for eight-bit words
    push();
    ticks(63);
    check("R2 before limit", age_flag, 0);
    ticks(1);
    check("R2 at limit", age_flag, 1);
    check("R9 irq on", age_irq, 1);
    check("R9 dma off", age_dma_req, 0);
    wr_stat(0);
    check("R8 write 0 keeps", age_flag, 1);
    wr_stat(1);
    check("R8 write 1 clears", age_flag, 0);
    check("R9 irq falls", age_irq, 0);

    // R7: no refire without a new char
    ticks(80);
    check("R7 no refire", age_flag, 0);

    // R3: 56 ticks for seven-bit words
    word_long = 0;
    push();
    ticks(55);
    check("R3 before limit", age_flag, 0);
    ticks(1);
    check("R3 at limit", age_flag, 1);
    wr_stat(1);

    // R4: push restarts count
    push();
    ticks(40);
    push();
    ticks(55);
    check("R4 restarted", age_flag, 0);
    ticks(1);
    check("R4 full after push", age_flag, 1);
    wr_stat(1);

    // R5: level at threshold holds count
    push();
    ticks(30);
    fill_level = 8;
    ticks(100);
    check("R5 held at thresh", age_flag, 0);
    fill_level = 3;
    ticks(55);
    check("R5 resumes from zero", age_flag, 0);
    ticks(1);
    check("R5 fires after resume", age_flag, 1);
    wr_stat(1);

    // R6: empty FIFO disarms
    push();
    ticks(20);
    fill_level = 0;
    ticks(100);
    check("R6 empty no fire", age_flag, 0);
    fill_level = 3;
    ticks(60);
    check("R6 stays disarmed", age_flag, 0);

    // R10: fire and clear collide; DMA routing
    irq_en = 0; dma_en = 1;
    push();
    ticks(56);
    check("R9 dma on", age_dma_req, 1);
    check("R9 irq gated", age_irq, 0);
    push();
    ticks(55);
    @(negedge clk) begin bit_tick = 1; stat_wr = 1; stat_wdata = 1; end
    @(negedge clk) begin bit_tick = 0; stat_wr = 0; stat_wdata = 0; end
    check("R10 set wins", age_flag, 1);
    wr_stat(1);
    check("R10 later clear", age_flag, 0);
    check("R9 dma falls", age_dma_req, 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule